// File: doc/BRIEF.md
# Three-Phase Brushless Motor Commutation Logic

This block turns the three Hall sensor levels of a brushless DC motor into drive enables for a three-phase bridge. For each valid rotor position it turns on one upper (source) phase and one lower (sink) phase. In reverse, the same six source/sink pairs come from the bitwise complement of the Hall code. A stop request shuts everything off. A brake request short-brakes the motor by closing all upper switches and opening all lower ones. A protection input, driven by lock detection, forces every upper switch open.

The active lower phase is chopped by an externally supplied PWM gate. The active upper phase stays steadily on. Every output leaves the block through registers, so the bridge drivers never see decode glitches. The number of output register stages and the use of the PWM gate are parameters.

Top module: `bldc_commutator`

## Requirements
- R1: Forward mapping (reverse_i=0). The Hall code is {hall_i[2],hall_i[1],hall_i[0]}. The phase vectors use bit0=U, bit1=V and bit2=W. The codes map to upper/lower as follows: 101 gives V/U, 100 gives W/U, 110 gives W/V, 010 gives U/V, 011 gives U/W and 001 gives V/W.
- R2: With reverse_i=1, the output is the R1 entry of the bitwise complement of the Hall code. The direction may change on any cycle, and the output reflects the new direction after the normal output latency.
- R3: stop_i=1 forces all six outputs to 0, whatever the other inputs are.
- R4: brake_i=1 with stop_i=0 and prot_off_i=0 gives upper_en_o=111 and lower_en_o=000, whatever the Hall code and the PWM gate are.
- R5: prot_off_i=1 with stop_i=0 forces upper_en_o=000. The lower outputs still follow the brake and commutation rules.
- R6: Hall codes 000 and 111, in either direction, give all outputs 0 when neither stop nor brake is active.
- R7: With pwm_i=0 all lower outputs are 0. With pwm_i=1 the active lower phase is on. The upper outputs do not depend on pwm_i.
- R8: Outputs are registered. During reset and after it they are 0 until the first clock edge loads new inputs. An input change becomes visible OUT_STAGES clock edges later (default 1).
- R9: No phase ever has its upper and lower enable on at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall levels, bit2=sensor 1, bit1=sensor 2, bit0=sensor 3 |
| reverse_i | input | 1 | 1 selects reverse rotation |
| stop_i | input | 1 | 1 stops the drive |
| brake_i | input | 1 | 1 requests short braking |
| prot_off_i | input | 1 | 1 forces all upper enables off |
| pwm_i | input | 1 | PWM gate for the active lower phase |
| upper_en_o | output | 3 | Upper (source) enables, bit0=U, bit1=V, bit2=W |
| lower_en_o | output | 3 | Lower (sink) enables, bit0=U, bit1=V, bit2=W |

## Verification
The hardest case to reach is protection combined with active commutation. The upper outputs must drop while the lower phase keeps chopping with the PWM gate. This happens only when stop and brake are both released, protection is set and the Hall code is valid. The stimulus therefore sweeps the full cross product of all eight Hall codes, both directions and every stop, brake, protection and PWM combination, one per cycle. A scoreboard holds the expected output for the following cycle. A separate run holds a valid Hall code and toggles the direction on every cycle, so that the output is seen to switch between the two mappings with no stale cycle.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

   localparam int unsigned PHASES = 3;

   typedef logic [PHASES-1:0] phase_vec_t;

   localparam phase_vec_t PH_NONE = 3'b000;
   localparam phase_vec_t PH_U    = 3'b001;
   localparam phase_vec_t PH_V    = 3'b010;
   localparam phase_vec_t PH_W    = 3'b100;
   localparam phase_vec_t PH_ALL  = 3'b111;

   typedef struct packed {
      phase_vec_t upper;
      phase_vec_t lower;
   } drive_t;

   localparam int unsigned DRIVE_W = $bits(drive_t);

   typedef struct packed {
      logic stop;
      logic brake;
      logic prot;
      logic pwm;
   } ctrl_t;

endpackage

// File: rtl/bldc_hall_decode.sv
module bldc_hall_decode
   import bldc_comm_pkg::*;
#(
   parameter int unsigned HALL_W = 3
) (
   input  logic [HALL_W-1:0] hall_i,
   input  logic              reverse_i,
   output phase_vec_t        src_o,
   output phase_vec_t        snk_o,
   output logic              valid_o
);

   if (HALL_W != PHASES) begin : g_bad_width
      $error("bldc_hall_decode: HALL_W must equal the phase count");
   end

   logic [HALL_W-1:0] code;

   // Reverse uses the complemented position code
   assign code = reverse_i ? ~hall_i : hall_i;

   always_comb begin
      src_o   = PH_NONE;
      snk_o   = PH_NONE;
      valid_o = 1'b1;
      unique case (code)
         3'b101:  begin src_o = PH_V; snk_o = PH_U; end
         3'b100:  begin src_o = PH_W; snk_o = PH_U; end
         3'b110:  begin src_o = PH_W; snk_o = PH_V; end
         3'b010:  begin src_o = PH_U; snk_o = PH_V; end
         3'b011:  begin src_o = PH_U; snk_o = PH_W; end
         3'b001:  begin src_o = PH_V; snk_o = PH_W; end
         default: valid_o = 1'b0;
      endcase
   end

   always_comb begin
      AST_PAIR_DISJOINT: assert (!valid_o || (((src_o & snk_o) == PH_NONE) && $onehot(src_o) && $onehot(snk_o)))
         else $error("decoded pair overlaps"); // R1
   end

endmodule

// File: rtl/bldc_drive_select.sv
module bldc_drive_select
   import bldc_comm_pkg::*;
#(
   parameter bit PWM_GATE_EN = 1'b1
) (
   input  phase_vec_t src_i,
   input  phase_vec_t snk_i,
   input  logic       valid_i,
   input  ctrl_t      ctrl_i,
   output drive_t     drive_o
);

   logic gate;

   if (PWM_GATE_EN) begin : g_pwm_gate
      assign gate = ctrl_i.pwm;
   end else begin : g_no_gate
      logic unused_pwm;
      assign unused_pwm = ctrl_i.pwm;
      assign gate       = 1'b1;
   end

   // Priority: stop, then protection, then brake, then commutation
   always_comb begin
      drive_o.upper = PH_NONE;
      drive_o.lower = PH_NONE;
      if (!ctrl_i.stop) begin
         if (ctrl_i.brake) begin
            drive_o.upper = PH_ALL;
         end else if (valid_i) begin
            drive_o.upper = src_i;
            drive_o.lower = gate ? snk_i : PH_NONE;
         end
         if (ctrl_i.prot) begin
            drive_o.upper = PH_NONE;
         end
      end
   end

   always_comb begin
      AST_SEL_NO_SHOOT: assert ((drive_o.upper & drive_o.lower) == PH_NONE)
         else $error("selected drive shoots through"); // R9
   end

endmodule

// File: rtl/bldc_out_pipe.sv
module bldc_out_pipe #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("bldc_out_pipe: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_comm_pkg::*;
#(
   parameter int unsigned OUT_STAGES  = 1,
   parameter bit          PWM_GATE_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] hall_i,
   input  logic       reverse_i,
   input  logic       stop_i,
   input  logic       brake_i,
   input  logic       prot_off_i,
   input  logic       pwm_i,
   output logic [2:0] upper_en_o,
   output logic [2:0] lower_en_o
);

   localparam int unsigned MAX_STAGES = 8;

   if (OUT_STAGES < 1 || OUT_STAGES > MAX_STAGES) begin : g_bad_cfg
      $error("bldc_commutator: OUT_STAGES out of range");
   end

   phase_vec_t src, snk;
   logic       pos_valid;
   ctrl_t      ctrl;
   drive_t     drive_d, drive_q;

   assign ctrl = '{stop: stop_i, brake: brake_i, prot: prot_off_i, pwm: pwm_i};

   bldc_hall_decode #(.HALL_W(PHASES)) u_decode (
      .hall_i    (hall_i),
      .reverse_i (reverse_i),
      .src_o     (src),
      .snk_o     (snk),
      .valid_o   (pos_valid)
   );

   bldc_drive_select #(.PWM_GATE_EN(PWM_GATE_EN)) u_select (
      .src_i   (src),
      .snk_i   (snk),
      .valid_i (pos_valid),
      .ctrl_i  (ctrl),
      .drive_o (drive_d)
   );

   bldc_out_pipe #(.WIDTH(DRIVE_W), .STAGES(OUT_STAGES)) u_pipe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (drive_d),
      .q_o    (drive_q)
   );

   assign upper_en_o = drive_q.upper;
   assign lower_en_o = drive_q.lower;

   // Marks that the previous edge was already out of reset
   logic live_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) live_q <= 1'b0;
      else         live_q <= 1'b1;
   end

   AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upper_en_o & lower_en_o) == 3'b000) else $error("shoot-through at outputs"); // R9

   if (OUT_STAGES == 1) begin : g_chk
      AST_STOP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (live_q && $past(stop_i)) |-> (upper_en_o == 3'b000 && lower_en_o == 3'b000))
         else $error("stop did not clear outputs"); // R3
      AST_BRAKE_ALL_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (live_q && $past(!stop_i && brake_i && !prot_off_i)) |-> (upper_en_o == 3'b111 && lower_en_o == 3'b000))
         else $error("brake pattern wrong"); // R4
      AST_PROT_UP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (live_q && $past(prot_off_i)) |-> (upper_en_o == 3'b000))
         else $error("protection left an upper phase on"); // R5
      AST_BAD_HALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (live_q && $past(!brake_i && (hall_i == 3'b000 || hall_i == 3'b111))) |-> (upper_en_o == 3'b000 && lower_en_o == 3'b000))
         else $error("invalid hall code drove a phase"); // R6
      if (PWM_GATE_EN) begin : g_pwm_chk
         AST_PWM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (live_q && $past(!pwm_i)) |-> (lower_en_o == 3'b000))
            else $error("lower phase on with gate low"); // R7
      end
   end

endmodule

// File: tb/bldc_commutator_tb_top.sv
module bldc_commutator_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall = 3'b000;
   logic       rev = 1'b0, stop = 1'b1, brake = 1'b0, prot = 1'b0, pwm = 1'b0;
   logic [2:0] up, lo;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bldc_commutator dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .hall_i     (hall),
      .reverse_i  (rev),
      .stop_i     (stop),
      .brake_i    (brake),
      .prot_off_i (prot),
      .pwm_i      (pwm),
      .upper_en_o (up),
      .lower_en_o (lo)
   );

   typedef struct {
      logic [2:0] hi;
      logic [2:0] lw;
      string      tag;
   } exp_t;

   exp_t sbq[$];
   exp_t cur;

   // Forward table from R1 (bit0=U, bit1=V, bit2=W)
   function automatic void fwd_pair(input logic [2:0] c, output logic [2:0] s,
                                    output logic [2:0] k, output bit ok);
      ok = 1'b1;
      case (c)
         3'b101: begin s = 3'b010; k = 3'b001; end
         3'b100: begin s = 3'b100; k = 3'b001; end
         3'b110: begin s = 3'b100; k = 3'b010; end
         3'b010: begin s = 3'b001; k = 3'b010; end
         3'b011: begin s = 3'b001; k = 3'b100; end
         3'b001: begin s = 3'b010; k = 3'b100; end
         default: begin s = 3'b000; k = 3'b000; ok = 1'b0; end
      endcase
   endfunction

   function automatic exp_t model(input logic [2:0] h, input logic r, input logic st,
                                  input logic br, input logic pr, input logic pw);
      exp_t e;
      logic [2:0] s, k;
      bit ok;
      fwd_pair(r ? ~h : h, s, k, ok);
      e.hi = 3'b000;
      e.lw = 3'b000;
      if (st)       e.tag = "R3";
      else if (pr)  e.tag = "R5";
      else if (br)  e.tag = "R4";
      else if (!ok) e.tag = "R6";
      else if (!pw) e.tag = "R7";
      else if (r)   e.tag = "R2";
      else          e.tag = "R1";
      if (!st) begin
         if (br) e.hi = 3'b111;
         else if (ok) begin
            e.hi = s;
            e.lw = pw ? k : 3'b000;
         end
         if (pr) e.hi = 3'b000;
      end
      return e;
   endfunction

   task automatic step(input logic [2:0] h, input logic r, input logic st,
                       input logic br, input logic pr, input logic pw);
      @(negedge clk);
      hall = h; rev = r; stop = st; brake = br; prot = pr; pwm = pw;
      sbq.push_back(model(h, r, st, br, pr, pw));
   endtask

   task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual up=%b lo=%b expected up=%b lo=%b",
                  tag, act[5:3], act[2:0], exp[5:3], exp[2:0]);
      end
   endtask

   // Monitor: one expected item per cycle, sampled after the edge
   always @(posedge clk) begin
      #3;
      if (sbq.size() > 0) begin
         cur = sbq.pop_front();
         check(cur.tag, {up, lo}, {cur.hi, cur.lw});
         check("R9", {3'b000, up & lo}, 6'b000000);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R8 in reset", {up, lo}, 6'b000000);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R8 after reset", {up, lo}, 6'b000000);

      // Full sweep: R1 R2 R3 R4 R5 R6 R7
      for (int i = 0; i < 256; i++) begin
         logic [7:0] v;
         v = i[7:0];
         step(v[2:0], v[3], v[4], v[5], v[6], v[7]);
      end

      // Direction toggled every cycle while running (R2)
      for (int i = 0; i < 8; i++) begin
         step(3'b110, i[0], 1'b0, 1'b0, 1'b0, 1'b1);
      end
      // Protection while commutating with gate chopping (R5, R7)
      for (int i = 0; i < 4; i++) begin
         step(3'b011, 1'b0, 1'b0, 1'b0, 1'b1, i[0]);
      end

      // Latency (R8): stop first, then a valid run pattern
      step(3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      stop = 1'b0;
      #1;
      check("R8 before edge", {up, lo}, 6'b000000);
      @(posedge clk);
      #3;
      check("R8 one edge later", {up, lo}, {3'b010, 3'b001});

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule